// File: doc/BRIEF.md
# Reference-Timer Frequency Calibrator

This block measures how fast a free-running 64-bit timestamp counter advances. It compares that counter against a slow 16-bit reference down-counter that runs at a known rate (1.193182 MHz by default) and reports the timestamp rate in whole MHz. The reference counter must already be loaded with 0xFFFF and counting. After `start`, the block polls the reference counter over a simple read port. Each poll is two strobed byte reads. The block follows the high byte as it steps down one value at a time and timestamps every poll that still matches.

The first high-byte change is the starting mark. At each later change the block compares the summed timing uncertainty of the two marks with the elapsed timestamp span shifted right by a fixed amount, which is about 500 ppm at a shift of 11. Once the uncertainty is small enough, one more poll confirms that the reference did not jump. A sequential divider then turns the span into MHz. A reference that is stuck, too fast, too slow or jumpy produces `fail` with a zero result.

Top module: `rate_calibrator`

## Requirements
- R1: While reset is held and after it is released, `done`, `fail` and `rd_stb` are low and `result_mhz` is zero.
- R2: Each poll drives `rd_stb` high for exactly two consecutive cycles, followed by at least one low cycle. Read data is taken one cycle after each strobe. The first byte (low byte) never affects the outcome. Only the second byte (high byte) is compared.
- R3: After an accepted `start`, the block makes one discarded poll before it begins tracking the value 0xFF.
- R4: A wait phase on an expected high byte polls until the first mismatch or until POLL_LIMIT matching polls. The phase is good only if more than MIN_POLLS (5) polls matched. Otherwise the run ends with `fail` high. A reference stuck at 0xFF and a reference that changes within a few polls therefore both fail.
- R5: The mark of a phase is the timestamp of its last matching poll. Its uncertainty is the timestamp at the phase exit minus the timestamp of the match before the last.
- R6: After the phase on 0xFF (index 0), phases wait on 0xFF − i for i = 1 up to MAX_ITER. MAX_ITER defaults to 50 ms × 1193182 / 1000 / 256 = 233.
- R7: After phase i, tracking continues while d0 + di ≥ (t_i − t_0) >> ERR_SHIFT, where ERR_SHIFT defaults to 11. Otherwise one more poll must read the high byte 0xFE − i, or the run fails.
- R8: On success, `result_mhz` = ((t_i − t_0) × 1193182) / (i × 256 × 10^6) with truncation. This equals the kHz rate truncated and then divided by 1000 with truncation.
- R9: If the bound is still not met after phase MAX_ITER, the run fails. Every failing run reports a zero result.
- R10: `done` is high for exactly one cycle per run. `fail` and `result_mhz` keep their values until the next accepted `start`.
- R11: A `start` pulse while a run is in progress is ignored and does not change that run's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timestamp is in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration run when idle |
| rd_stb | output | 1 | Byte read request to the reference counter |
| rd_data | input | 8 | Byte returned one cycle after each `rd_stb` |
| ts | input | TS_W (64) | Free-running timestamp counter |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Run ended without a valid measurement |
| result_mhz | output | RES_W (32) | Measured timestamp rate in MHz |

## Verification
The checker watches four things on every cycle: that `done` lasts one cycle, that a failed run holds a zero result, that `fail` and `result_mhz` do not move except at `start` or `done`, and that read strobes come in pairs separated by a gap. The bench alone can show the numbers. It drives a reference model with chosen tick rates, garbage low bytes, stuck and racing counters, and a one-off double step timed to land on the confirming poll. From each high byte and timestamp it actually delivered, it predicts the stop iteration, the pass or fail outcome and the MHz value.

// File: rtl/rcal_pkg.sv
package rcal_pkg;
    typedef enum logic [1:0] {
        PL_IDLE,
        PL_LO,
        PL_HI,
        PL_CHK
    } poll_st_e;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_DUMMY,
        CS_FIRST,
        CS_TRACK,
        CS_VERIFY,
        CS_DIVIDE
    } cal_st_e;
endpackage

// File: rtl/rcal_poll.sv
// One wait phase: poll the reference high byte until it differs from want_hi
// or the budget runs out; in one-shot mode a single poll reports a match.
module rcal_poll
    import rcal_pkg::*;
#(
    parameter int TS_W       = 64,
    parameter int POLL_LIMIT = 50000,
    parameter int MIN_POLLS  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            one_shot,
    input  logic [7:0]      want_hi,
    output logic            rd_stb,
    input  logic [7:0]      rd_data,
    input  logic [TS_W-1:0] ts,
    output logic            fin,
    output logic            ok,
    output logic [TS_W-1:0] mark_ts,
    output logic [TS_W-1:0] spread
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        poll_st_e        st;
        logic            shot;
        logic [CNT_W-1:0] cnt;
        logic [TS_W-1:0] cur;
        logic [TS_W-1:0] prev;
        logic            fin;
        logic            ok;
        logic [TS_W-1:0] spread;
    } poll_t;

    poll_t q, d;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        d       = q;
        d.fin   = 1'b0;
        cnt_inc = {1'b0, q.cnt} + 1'b1;
        case (q.st)
            PL_IDLE: if (go) begin
                d.st   = PL_LO;
                d.shot = one_shot;
                d.cnt  = '0;
                d.cur  = '0;
                d.prev = '0;
            end
            PL_LO: d.st = PL_HI;
            PL_HI: d.st = PL_CHK;
            PL_CHK: begin
                if (q.shot) begin
                    d.fin = 1'b1;
                    d.ok  = (rd_data == want_hi);
                    d.st  = PL_IDLE;
                end else if (rd_data == want_hi) begin
                    d.prev = q.cur;
                    d.cur  = ts;
                    d.cnt  = cnt_inc[CNT_W-1:0];
                    if (q.cnt == CNT_W'(POLL_LIMIT - 1)) begin
                        d.fin    = 1'b1;
                        d.ok     = cnt_inc > (CNT_W + 1)'(MIN_POLLS);
                        d.spread = ts - q.cur;
                        d.st     = PL_IDLE;
                    end else begin
                        d.st = PL_LO;
                    end
                end else begin
                    d.fin    = 1'b1;
                    d.ok     = q.cnt > CNT_W'(MIN_POLLS);
                    d.spread = ts - q.prev;
                    d.st     = PL_IDLE;
                end
            end
            default: d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_stb  = (q.st == PL_LO) || (q.st == PL_HI);
    assign fin     = q.fin;
    assign ok      = q.ok;
    assign mark_ts = q.cur;
    assign spread  = q.spread;
endmodule

// File: rtl/rcal_div.sv
// Restoring divider, one quotient bit per cycle.
module rcal_div #(
    parameter int NUM_W = 85,
    parameter int DEN_W = 36,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [OUT_W-1:0] quot
);
    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             fin;
        logic [CW-1:0]    cnt;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] dvs;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        trial = {q.rem, q.quo[NUM_W-1]};
        if (go) begin
            d.busy = 1'b1;
            d.cnt  = CW'(NUM_W);
            d.quo  = num;
            d.rem  = '0;
            d.dvs  = den;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.dvs}) begin
                d.rem = DEN_W'(trial - {1'b0, q.dvs});
                d.quo = {q.quo[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial[DEN_W-1:0];
                d.quo = {q.quo[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin  = q.fin;
    assign quot = q.quo[OUT_W-1:0];
endmodule

// File: rtl/rate_calibrator.sv
module rate_calibrator
    import rcal_pkg::*;
#(
    parameter int TS_W       = 64,
    parameter int RES_W      = 32,
    parameter int REF_HZ     = 1193182,
    parameter int WINDOW_MS  = 50,
    parameter int MAX_ITER   = (WINDOW_MS * REF_HZ / 1000) / 256,
    parameter int POLL_LIMIT = 50000,
    parameter int MIN_POLLS  = 5,
    parameter int ERR_SHIFT  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_stb,
    input  logic [7:0]       rd_data,
    input  logic [TS_W-1:0]  ts,
    output logic             done,
    output logic             fail,
    output logic [RES_W-1:0] result_mhz
);
    localparam int RATE_W = $clog2(REF_HZ + 1);
    localparam int NUM_W  = TS_W + RATE_W;
    localparam int UNIT   = 256 * 1000 * 1000;
    localparam int UNIT_W = $clog2(UNIT + 1);
    localparam int IT_W   = $clog2(MAX_ITER + 1);
    localparam int DEN_W  = IT_W + UNIT_W;

    typedef struct packed {
        cal_st_e          st;
        logic [IT_W-1:0]  iter;
        logic [TS_W-1:0]  t0;
        logic [TS_W-1:0]  d0;
        logic [TS_W-1:0]  span;
        logic [7:0]       want;
        logic             pgo;
        logic             pshot;
        logic             dgo;
        logic             done;
        logic             fail;
        logic [RES_W-1:0] res;
    } cal_t;

    cal_t q, d;

    logic             p_fin, p_ok;
    logic [TS_W-1:0]  p_mark, p_spread;
    logic             d_fin;
    logic [RES_W-1:0] d_quot;
    logic [TS_W-1:0]  elapsed;
    logic [TS_W:0]    unc_sum, bound;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;

    rcal_poll #(
        .TS_W(TS_W), .POLL_LIMIT(POLL_LIMIT), .MIN_POLLS(MIN_POLLS)
    ) u_poll (
        .clk(clk), .rst_n(rst_n), .go(q.pgo), .one_shot(q.pshot),
        .want_hi(q.want), .rd_stb(rd_stb), .rd_data(rd_data), .ts(ts),
        .fin(p_fin), .ok(p_ok), .mark_ts(p_mark), .spread(p_spread)
    );

    assign div_num = NUM_W'(q.span) * NUM_W'(REF_HZ);
    assign div_den = DEN_W'(q.iter) * DEN_W'(UNIT);

    rcal_div #(
        .NUM_W(NUM_W), .DEN_W(DEN_W), .OUT_W(RES_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .go(q.dgo), .num(div_num),
        .den(div_den), .fin(d_fin), .quot(d_quot)
    );

    always_comb begin
        d       = q;
        d.pgo   = 1'b0;
        d.dgo   = 1'b0;
        d.done  = 1'b0;
        elapsed = p_mark - q.t0;
        unc_sum = {1'b0, q.d0} + {1'b0, p_spread};
        bound   = {1'b0, elapsed >> ERR_SHIFT};
        case (q.st)
            CS_IDLE: if (start) begin
                d.fail  = 1'b0;
                d.res   = '0;
                d.pgo   = 1'b1;
                d.pshot = 1'b1;
                d.st    = CS_DUMMY;
            end
            CS_DUMMY: if (p_fin) begin
                d.pgo   = 1'b1;
                d.pshot = 1'b0;
                d.want  = 8'hFF;
                d.st    = CS_FIRST;
            end
            CS_FIRST: if (p_fin) begin
                if (!p_ok) begin
                    d.fail = 1'b1; d.done = 1'b1; d.st = CS_IDLE;
                end else begin
                    d.t0   = p_mark;
                    d.d0   = p_spread;
                    d.iter = IT_W'(1);
                    d.want = q.want - 8'd1;
                    d.pgo  = 1'b1;
                    d.st   = CS_TRACK;
                end
            end
            CS_TRACK: if (p_fin) begin
                if (!p_ok) begin
                    d.fail = 1'b1; d.done = 1'b1; d.st = CS_IDLE;
                end else if (unc_sum >= bound) begin
                    if (q.iter == IT_W'(MAX_ITER)) begin
                        d.fail = 1'b1; d.done = 1'b1; d.st = CS_IDLE;
                    end else begin
                        d.iter = q.iter + 1'b1;
                        d.want = q.want - 8'd1;
                        d.pgo  = 1'b1;
                    end
                end else begin
                    d.span  = elapsed;
                    d.want  = q.want - 8'd1;
                    d.pshot = 1'b1;
                    d.pgo   = 1'b1;
                    d.st    = CS_VERIFY;
                end
            end
            CS_VERIFY: if (p_fin) begin
                if (p_ok) begin
                    d.dgo = 1'b1;
                    d.st  = CS_DIVIDE;
                end else begin
                    d.fail = 1'b1; d.done = 1'b1; d.st = CS_IDLE;
                end
            end
            CS_DIVIDE: if (d_fin) begin
                d.res  = d_quot;
                d.done = 1'b1;
                d.st   = CS_IDLE;
            end
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done       = q.done;
    assign fail       = q.fail;
    assign result_mhz = q.res;
endmodule

// File: rtl/rcal_checker.sv
module rcal_checker #(
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_stb,
    input logic             done,
    input logic             fail,
    input logic [RES_W-1:0] result_mhz
);
    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a failed run never reports a nonzero rate
    a_r9_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (result_mhz == '0));

    // R10: outcome moves only at an accepted start or at completion
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || ($stable(fail) && $stable(result_mhz))));

    // R2: strobes come as a pair
    a_r2_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb) |=> rd_stb);

    // R2: a pair is followed by a gap
    a_r2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && $past(rd_stb)) |=> !rd_stb);
endmodule

bind rate_calibrator rcal_checker #(.RES_W(RES_W)) u_rcal_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_stb(rd_stb),
    .done(done), .fail(fail), .result_mhz(result_mhz)
);

// File: tb/rate_calibrator_bench.sv
`timescale 1ns/1ps
module rate_calibrator_bench;
    localparam int B_LIMIT = 1000;
    localparam int B_MAXIT = 12;
    localparam int B_SHIFT = 9;
    localparam int B_MIN   = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_stb;
    logic [7:0]  rd_data = 8'h00;
    logic [63:0] ts = 64'd0;
    logic        done, fail;
    logic [31:0] result_mhz;

    always #5 clk = ~clk;

    rate_calibrator #(
        .POLL_LIMIT(B_LIMIT), .MAX_ITER(B_MAXIT), .ERR_SHIFT(B_SHIFT)
    ) u_rate_calibrator (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_stb(rd_stb),
        .rd_data(rd_data), .ts(ts), .done(done), .fail(fail),
        .result_mhz(result_mhz)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    // reference counter and stimulus state
    logic [15:0] ref_cnt = 16'hFFFF;
    int ref_per = 4, ref_step = 1, tick = 0, trans = 0, dbl_at = 0;
    bit dbl_pend = 0, lo_garbage = 0, pend = 0, hi_next = 0;
    int req_start = 0;
    logic [63:0] ts_base = 64'd0;
    int run_len = 0, bad_pairs = 0;

    // model state: 0 idle, 1 dummy, 2 phase, 3 confirm, 4 finished
    int m_state = 0, m_cnt = 0, m_iter = 0, m_iter_final = 0;
    logic [7:0]  m_want;
    logic [63:0] m_cur, m_prev, m_t0, m_d0, m_span;
    bit m_fail;
    logic [31:0] m_res;

    task automatic model_finish(input bit f);
        m_fail = f;
        m_state = 4;
        if (f) m_res = 32'd0;
    endtask

    task automatic model_phase_end(input logic [63:0] dl);
        logic [64:0] lhs, rhs;
        logic [63:0] el;
        if (m_cnt <= B_MIN) begin
            model_finish(1'b1);
        end else if (m_iter == 0) begin
            m_t0 = m_cur; m_d0 = dl; m_iter = 1; m_want = 8'hFE;
            m_cnt = 0; m_cur = 0; m_prev = 0;
        end else begin
            el  = m_cur - m_t0;
            lhs = {1'b0, m_d0} + {1'b0, dl};
            rhs = {1'b0, el >> B_SHIFT};
            if (lhs >= rhs) begin
                if (m_iter == B_MAXIT) model_finish(1'b1);
                else begin
                    m_iter++; m_want = m_want - 8'd1;
                    m_cnt = 0; m_cur = 0; m_prev = 0;
                end
            end else begin
                m_span = el; m_want = m_want - 8'd1; m_state = 3;
            end
        end
    endtask

    task automatic model_step(input logic [7:0] hi, input logic [63:0] t);
        logic [127:0] num, den, q;
        case (m_state)
            1: begin
                m_state = 2; m_want = 8'hFF; m_iter = 0;
                m_cnt = 0; m_cur = 0; m_prev = 0;
            end
            2: begin
                if (hi == m_want) begin
                    m_prev = m_cur; m_cur = t; m_cnt++;
                    if (m_cnt == B_LIMIT) model_phase_end(t - m_prev);
                end else begin
                    model_phase_end(t - m_prev);
                end
            end
            3: begin
                if (hi == m_want) begin
                    num = 128'(m_span) * 128'd1193182;
                    den = 128'(m_iter) * 128'd256000000;
                    q = num / den;
                    m_res = q[31:0];
                    m_iter_final = m_iter;
                    model_finish(1'b0);
                end else model_finish(1'b1);
            end
            default: ;
        endcase
    endtask

    // reference counter, timestamp and read responder
    initial begin
        logic [15:0] old;
        forever begin
            @(negedge clk);
            ts = ts + 64'd1;
            start = 1'b0;
            if (dbl_pend) begin ref_cnt = ref_cnt - 16'h0100; dbl_pend = 0; end
            if (req_start == 1) begin
                start = 1'b1; ts = ts_base; ref_cnt = 16'hFFFF; tick = 0;
                trans = 0; hi_next = 0; m_state = 1; req_start = 0;
            end else if (req_start == 2) begin
                start = 1'b1; req_start = 0;
            end else if (ref_per != 0) begin
                tick++;
                if (tick >= ref_per) begin
                    tick = 0; old = ref_cnt;
                    ref_cnt = ref_cnt - 16'(ref_step);
                    if (old[15:8] != ref_cnt[15:8]) begin
                        trans++;
                        if (dbl_at != 0 && trans == dbl_at) dbl_pend = 1;
                    end
                end
            end
            if (pend) begin
                if (hi_next) begin
                    rd_data = ref_cnt[15:8];
                    model_step(rd_data, ts);
                end else begin
                    rd_data = lo_garbage ? 8'($urandom) : ref_cnt[7:0];
                end
                hi_next = !hi_next;
            end
            pend = rd_stb;
            if (rd_stb) run_len++;
            else begin
                if (run_len != 0 && run_len != 2) bad_pairs++;
                run_len = 0;
            end
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expect: 0 pass, 1 fail, 2 taken from model only
    task automatic run(input int per, input int step, input bit garb, input int dbl,
                       input bit busy_start, input int expect_f,
                       input logic [63:0] base, input string req);
        int waited;
        logic [31:0] r_keep;
        bit f_keep;
        ref_per = per; ref_step = step; lo_garbage = garb; dbl_at = dbl;
        ts_base = base; req_start = 1;
        @(negedge clk); @(negedge clk);
        if (busy_start) begin
            repeat (400) @(negedge clk);
            req_start = 2;
        end
        waited = 0;
        while (!done && waited < 60000) begin
            @(negedge clk); waited++;
        end
        check(done == 1'b1, req, "done seen", 64'(done), 64'd1);
        check(m_state == 4, req, "model finished", 64'(m_state), 64'd4);
        check(fail == m_fail, req, "fail flag", 64'(fail), 64'(m_fail));
        check(result_mhz == m_res, req, "result MHz", 64'(result_mhz), 64'(m_res));
        if (expect_f != 2)
            check(fail == expect_f[0], req, "expected outcome", 64'(fail), 64'(expect_f));
        if (fail)
            check(result_mhz == 0, "R9", "zero on fail", 64'(result_mhz), 64'd0);
        r_keep = result_mhz; f_keep = fail;
        @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
        repeat (20) @(negedge clk);
        check(result_mhz == r_keep && fail == f_keep, "R10", "outcome held",
              64'(result_mhz), 64'(r_keep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int i_s, p;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(done == 0 && fail == 0 && rd_stb == 0 && result_mhz == 0, "R1",
              "in reset", 64'(result_mhz), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done == 0 && fail == 0 && rd_stb == 0, "R1", "after reset flags",
              64'({done, fail, rd_stb}), 64'd0);
        check(result_mhz == 0, "R1", "after reset result", 64'(result_mhz), 64'd0);

        // R3 R5 R6 R7 R8: nominal measurement
        run(4, 1, 0, 0, 0, 0, 64'd1000, "R8");
        i_s = m_iter_final;
        check(i_s > 1 && i_s <= B_MAXIT, "R6", "stop iteration in range",
              64'(i_s), 64'(B_MAXIT));
        // R2: low byte is noise
        run(5, 1, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_F000, "R2");
        // R5 R8: random rates and timestamp bases
        for (int k = 0; k < 2; k++) begin
            p = 4 + int'($urandom % 5);
            run(p, 1, 1'($urandom), 0, 0, 0, {$urandom, $urandom}, "R5");
        end
        // R9: bound unreachable within iteration budget
        run(1, 1, 0, 0, 0, 1, 64'd77, "R9");
        // R4: stuck reference exhausts poll budget on 0xFF then fails next phase
        run(0, 1, 0, 0, 0, 1, 64'd5, "R4");
        // R4: racing reference gives too few matching polls
        run(1, 64, 0, 0, 0, 1, 64'd9, "R4");
        // R7: double step on the final transition breaks the confirming poll
        run(4, 1, 0, i_s + 1, 0, 1, 64'd1000, "R7");
        // R11: start while busy ignored
        run(6, 1, 0, 0, 1, 0, 64'd300, "R11");
        check(bad_pairs == 0, "R2", "strobe pairing", 64'(bad_pairs), 64'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule